// File: doc/BRIEF.md
# Privileged instruction legality checker

This block decides whether a privileged wait or address-translation fence instruction may run under the current privilege and virtualization state. The decode stage presents one request: the instruction class, the current privilege, a virtualized flag, two configuration flags saying whether supervisor mode and the hypervisor are implemented, and four trap-enable bits from the status registers. The request carries a single-cycle strobe. The verdict is registered and appears one cycle later. It is one of three results: the instruction proceeds, it raises an illegal-instruction exception, or it raises a virtual-instruction fault. A permitted wait instruction also raises a halt request toward the core's sleep logic.

Every rule class is a separate combinational module. Each one reports raw "illegal" and "virtual fault" conditions. The top module applies a single priority, in which illegal wins over a virtual fault, and then registers the outcome. The request side has no ready signal and there is no back-pressure: the block accepts a request on every cycle that `req_valid` is high. The response is a one-cycle `rsp_valid` pulse, and the consumer must take it in that cycle. Between pulses, `rsp_code` and `rsp_halt` keep the last verdict.

Top module: `priv_insn_gate`

## Requirements
- R1: When `req_valid` is high at a rising edge, `rsp_valid` is high for exactly the next cycle, and `rsp_code` / `rsp_halt` carry the verdict for that request. While `req_valid` is low, `rsp_valid` is low and the outputs hold their values. The verdict encoding is 00 = allow, 01 = illegal instruction, 10 = virtual-instruction fault. The value 11 never appears.
- R2: The class encoding is 00 = wait-for-interrupt, 01 = supervisor fence, 10 = guest-virtual hypervisor fence, 11 = guest-physical hypervisor fence. The privilege encoding is 00 = user, 01 = supervisor, 11 = machine. A wait is illegal when `trap_tw` is set and the privilege is supervisor. It is also illegal when `trap_tw` is set, the privilege is user and `cfg_s_present` is low.
- R3: A wait is illegal in user mode when `cfg_s_present` is high and `req_virt` is low.
- R4: A wait that is not illegal produces a virtual fault when `req_virt` is high and the privilege is user. It also produces a virtual fault when `req_virt` is high, the privilege is supervisor and `trap_vtw` is set. Otherwise the wait is allowed.
- R5: A supervisor fence is illegal in user mode. It is also illegal in supervisor mode with `trap_tvm` set. Otherwise it produces a virtual fault when `cfg_h_present`, `req_virt` and `trap_vtvm` are all high. In every other case it is allowed.
- R6: Both hypervisor fences produce a virtual fault in supervisor mode with `req_virt` high. They are allowed in machine mode and in supervisor mode with `req_virt` low. They are illegal in user mode.
- R7: The guest-physical hypervisor fence is illegal in supervisor mode with `req_virt` low and `trap_tvm` set. This rule takes precedence over R6.
- R8: When the illegal condition and the virtual-fault condition of one class both hold, the verdict is illegal (01).
- R9: `rsp_halt` is high only together with an allow verdict for a wait instruction. It is low for every other verdict.
- R10: Privilege code 10 is reserved. Any class requested under it is illegal.
- R11: After reset, `rsp_valid`, `rsp_code` and `rsp_halt` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, one request per high cycle |
| req_class | input | 2 | Instruction class |
| req_priv | input | 2 | Current privilege level |
| req_virt | input | 1 | Core is running virtualized |
| cfg_s_present | input | 1 | Supervisor mode implemented |
| cfg_h_present | input | 1 | Hypervisor implemented |
| trap_tw | input | 1 | Trap wait-for-interrupt below machine mode |
| trap_tvm | input | 1 | Trap translation management in supervisor mode |
| trap_vtw | input | 1 | Trap wait-for-interrupt in virtualized supervisor mode |
| trap_vtvm | input | 1 | Trap translation management in virtualized supervisor mode |
| rsp_valid | output | 1 | Verdict strobe, one cycle after the request |
| rsp_code | output | 2 | Verdict: 00 allow, 01 illegal, 10 virtual fault |
| rsp_halt | output | 1 | Halt request for an allowed wait |

## Verification
The block has no sizing parameters. It is built as it stands: 2-bit class and privilege fields, with every flag and trap bit one bit wide. That leaves 2048 input combinations, so the bench walks all of them. This covers the reserved privilege code, the states where virtualization is flagged in machine mode, and every case where an illegal condition and a virtual-fault condition overlap. After each request the bench also spends one idle cycle checking that the strobe drops and the verdict holds.

// File: rtl/priv_gate_pkg.sv
package priv_gate_pkg;
  localparam int CLASS_W = 2;
  localparam int PRIV_W  = 2;
  localparam int CODE_W  = 2;

  typedef enum logic [CLASS_W-1:0] {
    CLS_WAIT      = 2'b00,
    CLS_SFENCE    = 2'b01,
    CLS_HFENCE_GV = 2'b10,
    CLS_HFENCE_GP = 2'b11
  } insn_class_e;

  typedef enum logic [PRIV_W-1:0] {
    PRV_USER  = 2'b00,
    PRV_SUPER = 2'b01,
    PRV_RSVD  = 2'b10,
    PRV_MACH  = 2'b11
  } priv_e;

  typedef enum logic [CODE_W-1:0] {
    VERDICT_ALLOW = 2'b00,
    VERDICT_ILL   = 2'b01,
    VERDICT_VIRT  = 2'b10
  } verdict_e;

  typedef struct packed {
    logic ill;
    logic vfault;
  } raw_fault_t;
endpackage

// File: rtl/wait_rule.sv
module wait_rule
  import priv_gate_pkg::*;
(
  input  logic       is_user,
  input  logic       is_super,
  input  logic       virt,
  input  logic       s_present,
  input  logic       tw,
  input  logic       vtw,
  output raw_fault_t fault
);
  logic tw_hit;
  logic user_no_virt;

  always_comb begin
    tw_hit       = tw && (is_super || (is_user && !s_present));
    user_no_virt = is_user && s_present && !virt;
    fault.ill    = tw_hit || user_no_virt;
    fault.vfault = virt && (is_user || (is_super && vtw));
  end
endmodule

// File: rtl/sfence_rule.sv
module sfence_rule
  import priv_gate_pkg::*;
(
  input  logic       is_user,
  input  logic       is_super,
  input  logic       virt,
  input  logic       h_present,
  input  logic       tvm,
  input  logic       vtvm,
  output raw_fault_t fault
);
  always_comb begin
    fault.ill    = is_user || (is_super && tvm);
    fault.vfault = h_present && virt && vtvm;
  end
endmodule

// File: rtl/hfence_rule.sv
module hfence_rule
  import priv_gate_pkg::*;
#(
  parameter bit GUEST_PHYS = 1'b0
)(
  input  logic       is_super,
  input  logic       is_mach,
  input  logic       virt,
  input  logic       tvm,
  output raw_fault_t fault
);
  logic base_ill;
  logic extra_ill;

  always_comb begin
    base_ill     = !(is_mach || is_super);
    fault.vfault = is_super && virt;
  end

  generate
    if (GUEST_PHYS) begin : g_phys
      always_comb extra_ill = is_super && !virt && tvm;
    end else begin : g_virt
      always_comb extra_ill = 1'b0;
    end
  endgenerate

  always_comb fault.ill = base_ill || extra_ill;
endmodule

// File: rtl/priv_insn_gate.sv
module priv_insn_gate
  import priv_gate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [CLASS_W-1:0] req_class,
  input  logic [PRIV_W-1:0]  req_priv,
  input  logic              req_virt,
  input  logic              cfg_s_present,
  input  logic              cfg_h_present,
  input  logic              trap_tw,
  input  logic              trap_tvm,
  input  logic              trap_vtw,
  input  logic              trap_vtvm,
  output logic              rsp_valid,
  output logic [CODE_W-1:0]  rsp_code,
  output logic              rsp_halt
);
  logic       is_user, is_super, is_mach, is_rsvd;
  raw_fault_t f_wait, f_sfence, f_hgv, f_hgp, f_sel;
  verdict_e   verdict_d;
  logic       halt_d;

  always_comb begin
    is_user  = (req_priv == PRV_USER);
    is_super = (req_priv == PRV_SUPER);
    is_mach  = (req_priv == PRV_MACH);
    is_rsvd  = (req_priv == PRV_RSVD);
  end

  wait_rule u_wait (
    .is_user(is_user), .is_super(is_super), .virt(req_virt),
    .s_present(cfg_s_present), .tw(trap_tw), .vtw(trap_vtw),
    .fault(f_wait)
  );

  sfence_rule u_sfence (
    .is_user(is_user), .is_super(is_super), .virt(req_virt),
    .h_present(cfg_h_present), .tvm(trap_tvm), .vtvm(trap_vtvm),
    .fault(f_sfence)
  );

  hfence_rule #(.GUEST_PHYS(1'b0)) u_hfence_gv (
    .is_super(is_super), .is_mach(is_mach), .virt(req_virt),
    .tvm(trap_tvm), .fault(f_hgv)
  );

  hfence_rule #(.GUEST_PHYS(1'b1)) u_hfence_gp (
    .is_super(is_super), .is_mach(is_mach), .virt(req_virt),
    .tvm(trap_tvm), .fault(f_hgp)
  );

  always_comb begin
    unique case (insn_class_e'(req_class))
      CLS_WAIT:      f_sel = f_wait;
      CLS_SFENCE:    f_sel = f_sfence;
      CLS_HFENCE_GV: f_sel = f_hgv;
      default:       f_sel = f_hgp;
    endcase
    if (is_rsvd || f_sel.ill) verdict_d = VERDICT_ILL;
    else if (f_sel.vfault)    verdict_d = VERDICT_VIRT;
    else                      verdict_d = VERDICT_ALLOW;
    halt_d = (verdict_d == VERDICT_ALLOW) && (req_class == CLS_WAIT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_code  <= VERDICT_ALLOW;
      rsp_halt  <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_code <= verdict_d;
        rsp_halt <= halt_d;
      end
    end
  end
endmodule

// File: rtl/priv_insn_gate_chk.sv
module priv_insn_gate_chk
  import priv_gate_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [CLASS_W-1:0] req_class,
  input logic [PRIV_W-1:0]  req_priv,
  input logic              rsp_valid,
  input logic [CODE_W-1:0]  rsp_code,
  input logic              rsp_halt
);
  p_strobe_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_strobe_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && $stable(rsp_code) && $stable(rsp_halt)));
  p_code_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_code != 2'b11);
  p_halt_allow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_halt |-> (rsp_code == VERDICT_ALLOW));
  p_halt_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_class != CLS_WAIT) |=> !rsp_halt);
  p_rsvd_priv_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_priv == PRV_RSVD) |=> (rsp_code == VERDICT_ILL));
  p_sfence_user_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_class == CLS_SFENCE && req_priv == PRV_USER)
      |=> (rsp_code == VERDICT_ILL));
  p_hfence_mach_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_class[1] && req_priv == PRV_MACH)
      |=> (rsp_code == VERDICT_ALLOW));
endmodule

bind priv_insn_gate priv_insn_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_class(req_class),
  .req_priv(req_priv), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
  .rsp_halt(rsp_halt)
);

// File: tb/sim_priv_insn_gate.sv
module sim_priv_insn_gate;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [1:0] req_class = 2'b00;
  logic [1:0] req_priv = 2'b00;
  logic       req_virt = 1'b0;
  logic       cfg_s_present = 1'b0;
  logic       cfg_h_present = 1'b0;
  logic       trap_tw = 1'b0;
  logic       trap_tvm = 1'b0;
  logic       trap_vtw = 1'b0;
  logic       trap_vtvm = 1'b0;
  logic       rsp_valid;
  logic [1:0] rsp_code;
  logic       rsp_halt;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  priv_insn_gate u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_class(req_class),
    .req_priv(req_priv), .req_virt(req_virt), .cfg_s_present(cfg_s_present),
    .cfg_h_present(cfg_h_present), .trap_tw(trap_tw), .trap_tvm(trap_tvm),
    .trap_vtw(trap_vtw), .trap_vtvm(trap_vtvm), .rsp_valid(rsp_valid),
    .rsp_code(rsp_code), .rsp_halt(rsp_halt)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Independent model: returns verdict, halt flag and deciding requirement.
  task automatic model(input logic [1:0] c, input logic [1:0] p, input bit v,
                       input bit s, input bit h, input bit tw, input bit tvm,
                       input bit vtw, input bit vtvm,
                       output logic [1:0] code, output bit halt, output string tag);
    bit u, su, m, ill, vf;
    u = (p == 2'd0); su = (p == 2'd1); m = (p == 2'd3);
    halt = 1'b0; ill = 1'b0; vf = 1'b0; tag = "";
    if (p == 2'd2) begin ill = 1'b1; tag = "R10"; end
    else if (c == 2'd0) begin
      if (tw && (su || (u && !s))) begin ill = 1'b1; tag = "R2"; end
      else if (u && s && !v) begin ill = 1'b1; tag = "R3"; end
      vf = v && (u || (su && vtw));
      if (!ill) tag = vf ? "R4" : "R9";
    end else if (c == 2'd1) begin
      ill = u || (su && tvm);
      vf = h && v && vtvm;
      tag = "R5";
    end else begin
      if (c == 2'd3 && su && !v && tvm) begin ill = 1'b1; tag = "R7"; end
      else begin
        vf = su && v;
        ill = !(m || su);
        tag = "R6";
      end
    end
    if (ill && vf) tag = "R8";
    code = ill ? 2'b01 : (vf ? 2'b10 : 2'b00);
    halt = (c == 2'd0) && (code == 2'b00);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [1:0] exp_code;
    bit         exp_halt;
    string      tag;
    repeat (3) @(negedge clk);
    check("R11 valid", {31'd0, rsp_valid}, 32'd0);
    check("R11 code", {30'd0, rsp_code}, 32'd0);
    check("R11 halt", {31'd0, rsp_halt}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 2048; i++) begin
      req_class = i[1:0];
      req_priv  = i[3:2];
      req_virt  = i[4];
      cfg_s_present = i[5];
      cfg_h_present = i[6];
      trap_tw   = i[7];
      trap_tvm  = i[8];
      trap_vtw  = i[9];
      trap_vtvm = i[10];
      req_valid = 1'b1;
      model(i[1:0], i[3:2], i[4], i[5], i[6], i[7], i[8], i[9], i[10],
            exp_code, exp_halt, tag);
      @(negedge clk);
      check("R1 strobe", {31'd0, rsp_valid}, 32'd1);
      check({tag, " code"}, {30'd0, rsp_code}, {30'd0, exp_code});
      check({tag, " halt R9"}, {31'd0, rsp_halt}, {31'd0, exp_halt});
      req_valid = 1'b0;
      req_class = ~req_class;
      req_priv  = ~req_priv;
      trap_tw   = ~trap_tw;
      @(negedge clk);
      check("R1 idle strobe", {31'd0, rsp_valid}, 32'd0);
      check("R1 held code", {30'd0, rsp_code}, {30'd0, exp_code});
      check("R1 held halt", {31'd0, rsp_halt}, {31'd0, exp_halt});
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule